// File: doc/BRIEF.md
# SD Card SPI-Mode Command Engine

This block runs a single command transaction against an SD card attached in SPI mode. It works one byte at a time through a separate byte-exchange shifter: each byte it puts out returns one byte from the card. A host controller gives it a command index, a 32-bit argument and a flag that marks an application command, then pulses a start strobe. The engine builds the six-byte command packet and handles chip-select. It waits for the card to be ready, inserts the application prefix when the flag asks for it, and polls for the one-byte status reply. It retries when no reply comes and collects whatever follows the reply for the given command.

When the transaction ends, the engine pulses a done flag. With it, the engine presents the status byte, any 32-bit trailing value, a classified result code and a flag that shows whether a ready or busy wait ran out of bytes. For the block-transfer commands it leaves the card selected after a clean reply, so a data-phase engine can take over the bus without a gap.

Top module: `sd_cmd_engine`

## Requirements
- R1: The packet has six bytes. Byte 0 is 0x40 OR the 6-bit command index. Bytes 1 to 4 are the argument, most significant byte first. Byte 5 is the check byte.
- R2: The check byte is 0x95 for index 0, 0x87 for index 8 and 0xFF for every other index.
- R3: Each transaction opens with one 0xFF byte sent while chip-select is high. Chip-select then goes low, and the engine sends 0xFF bytes until the card returns 0xFF. If RDY_LIMIT bytes pass without 0xFF, timeout_o is set and the transaction goes on. Index 12 skips this ready wait.
- R4: After the packet for index 12, the first returned byte is thrown away and is never taken as the reply.
- R5: After a packet, the engine sends up to 16 polling bytes of 0xFF. The reply is the first returned byte with bit 7 clear. If all 16 have bit 7 set, the reply is 0xFF.
- R6: When app_cmd_i is set, the packet for index 55 with argument 0 goes first. The engine polls for its reply, runs a ready wait, and then sends the requested command.
- R7: A reply of 0xFF starts a new attempt, up to 3 attempts in all. Each new attempt resends the packet without a fresh ready wait, and puts the index 55 prefix in front again when app_cmd_i was set.
- R8: status_o is set from the reply, checked in this priority order:
  - 0xFF gives 1 (no device).
  - Bit 3 gives 2 (CRC).
  - Bit 2 gives 3 (illegal command).
  - Bit 1 or bit 4 gives 4 (erase).
  - Bit 5 or bit 6 gives 5 (parameter).
  - Anything else gives 0 (OK).
- R9: For index 8 or index 58, when the status is not 1, 2 or 3, four more bytes are read, most significant first, into trail_o.
- R10: For index 12 or index 38, when the status is not 1, 2 or 3, the engine sends 0xFF bytes until it gets 0xFF back. If BUSY_LIMIT bytes pass without 0xFF, timeout_o is set.
- R11: With status 0 and index 9, 17, 18, 24 or 25, chip-select stays low when done_o pulses. In every other case chip-select goes high and one more 0xFF byte is sent before done_o. done_o is a one-cycle pulse.
- R12: After reset, chip-select is high, and spi_start_o, done_o and busy_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a transaction while the engine is idle |
| cmd_idx_i | input | 6 | Command index |
| cmd_arg_i | input | 32 | Command argument |
| app_cmd_i | input | 1 | Put the index 55 prefix in front of the command |
| spi_tx_o | output | 8 | Byte to send on the next exchange |
| spi_start_o | output | 1 | One-cycle request for a byte exchange |
| spi_rx_i | input | 8 | Returned byte, valid with spi_done_i |
| spi_done_i | input | 1 | The byte exchange is complete |
| cs_n_o | output | 1 | Card chip-select, active low |
| busy_o | output | 1 | A transaction is in progress |
| done_o | output | 1 | One-cycle pulse when the transaction ends |
| r1_o | output | 8 | Reply status byte |
| trail_o | output | 32 | Trailing value for index 8 or 58 |
| status_o | output | 3 | Classified result code |
| timeout_o | output | 1 | A ready or busy wait ran out of bytes |

## Verification
The cases hardest to reach from the ports depend on how many bytes pass before something happens. Examples are a reply arriving on the last of the 16 polls, a third attempt after two silent ones, and a ready or busy wait that uses up its limit. The bench card model replays a per-exchange script of returned bytes, indexed by the exchange count. Each of these cases is then just a script that puts the decisive byte at an exact position, and the bench checks the total exchange count and the bytes logged at known positions. The discarded byte after index 12 is scripted to look like a valid reply, so any engine that fails to drop it reports the wrong status byte.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [5:0] IDX_APP   = 6'd55;
  localparam logic [5:0] IDX_STOP  = 6'd12;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_NODEV   = 3'd1,
    ST_CRC     = 3'd2,
    ST_ILLEGAL = 3'd3,
    ST_ERASE   = 3'd4,
    ST_PARAM   = 3'd5
  } sd_status_e;

  typedef enum logic [3:0] {
    S_IDLE, S_FILL, S_RDY, S_SEND, S_STUFF, S_POLL, S_TRAIL, S_BUSY, S_END, S_DESEL
  } sd_state_e;

  function automatic logic keeps_select(input logic [5:0] idx);
    return idx inside {6'd9, 6'd17, 6'd18, 6'd24, 6'd25};
  endfunction

  function automatic logic has_trailer(input logic [5:0] idx);
    return idx inside {6'd8, 6'd58};
  endfunction

  function automatic logic has_busy(input logic [5:0] idx);
    return idx inside {6'd12, 6'd38};
  endfunction

endpackage

// File: rtl/sd_cmd_framer.sv
module sd_cmd_framer (
  input  logic [5:0]  idx_i,
  input  logic [31:0] arg_i,
  input  logic [2:0]  sel_i,
  output logic [7:0]  byte_o
);
  localparam int ARG_BYTES = 4;

  logic [7:0] arg_b [ARG_BYTES];
  logic [7:0] chk_b;

  for (genvar g = 0; g < ARG_BYTES; g++) begin : g_arg
    assign arg_b[g] = arg_i[31-8*g -: 8];
  end

  always_comb begin
    case (idx_i)
      6'd0:    chk_b = 8'h95;
      6'd8:    chk_b = 8'h87;
      default: chk_b = 8'hFF;
    endcase
  end

  always_comb begin
    case (sel_i)
      3'd0:    byte_o = {2'b01, idx_i};
      3'd1:    byte_o = arg_b[0];
      3'd2:    byte_o = arg_b[1];
      3'd3:    byte_o = arg_b[2];
      3'd4:    byte_o = arg_b[3];
      3'd5:    byte_o = chk_b;
      default: byte_o = 8'hFF;
    endcase
  end
endmodule

// File: rtl/sd_r1_classify.sv
module sd_r1_classify
  import sd_cmd_pkg::*;
(
  input  logic [7:0]  r1_i,
  output sd_status_e  status_o
);
  always_comb begin
    if (r1_i == 8'hFF)          status_o = ST_NODEV;
    else if (r1_i[3])           status_o = ST_CRC;
    else if (r1_i[2])           status_o = ST_ILLEGAL;
    else if (r1_i[1] | r1_i[4]) status_o = ST_ERASE;
    else if (r1_i[5] | r1_i[6]) status_o = ST_PARAM;
    else                        status_o = ST_OK;
  end
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sd_cmd_pkg::*;
#(
  parameter int RDY_LIMIT  = 4096,
  parameter int BUSY_LIMIT = 65536,
  parameter int POLL_MAX   = 16,
  parameter int ATTEMPTS   = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [5:0]  cmd_idx_i,
  input  logic [31:0] cmd_arg_i,
  input  logic        app_cmd_i,
  output logic [7:0]  spi_tx_o,
  output logic        spi_start_o,
  input  logic [7:0]  spi_rx_i,
  input  logic        spi_done_i,
  output logic        cs_n_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [7:0]  r1_o,
  output logic [31:0] trail_o,
  output logic [2:0]  status_o,
  output logic        timeout_o
);
  localparam int LIM_A = (RDY_LIMIT > BUSY_LIMIT) ? RDY_LIMIT : BUSY_LIMIT;
  localparam int LIM   = (LIM_A > POLL_MAX) ? LIM_A : POLL_MAX;
  localparam int CW    = $clog2(LIM + 1);
  localparam int TW    = $clog2(ATTEMPTS + 1);
  localparam logic [CW-1:0] RDY_LAST  = CW'(RDY_LIMIT - 1);
  localparam logic [CW-1:0] BUSY_LAST = CW'(BUSY_LIMIT - 1);
  localparam logic [CW-1:0] POLL_LAST = CW'(POLL_MAX - 1);
  localparam logic [CW-1:0] PKT_LAST  = CW'(5);
  localparam logic [CW-1:0] TRL_LAST  = CW'(3);
  localparam logic [TW-1:0] TRY_LAST  = TW'(ATTEMPTS - 1);

  sd_state_e  state_q;
  logic          pend_q, cs_n_q, done_q, tout_q, is55_q, app_q;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] tries_q;
  logic [5:0]    cmd_q;
  logic [31:0]   arg_q, trail_q;
  logic [7:0]    r1_q;
  sd_status_e    status_q;

  logic       got;
  logic [7:0] frame_b, poll_b;
  sd_status_e poll_cls;

  sd_cmd_framer u_framer (
    .idx_i  (is55_q ? IDX_APP : cmd_q),
    .arg_i  (is55_q ? 32'd0 : arg_q),
    .sel_i  (cnt_q[2:0]),
    .byte_o (frame_b)
  );

  assign poll_b = spi_rx_i[7] ? FILL_BYTE : spi_rx_i;

  sd_r1_classify u_cls (
    .r1_i     (poll_b),
    .status_o (poll_cls)
  );

  logic byte_phase;
  assign byte_phase  = !(state_q inside {S_IDLE, S_END});
  assign spi_start_o = byte_phase && !pend_q;
  assign spi_tx_o    = (state_q == S_SEND) ? frame_b : FILL_BYTE;
  assign got         = pend_q && spi_done_i;

  assign cs_n_o    = cs_n_q;
  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = done_q;
  assign r1_o      = r1_q;
  assign trail_o   = trail_q;
  assign status_o  = status_q;
  assign timeout_o = tout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      pend_q   <= 1'b0;
      cs_n_q   <= 1'b1;
      done_q   <= 1'b0;
      tout_q   <= 1'b0;
      is55_q   <= 1'b0;
      app_q    <= 1'b0;
      cnt_q    <= '0;
      tries_q  <= '0;
      cmd_q    <= '0;
      arg_q    <= '0;
      trail_q  <= '0;
      r1_q     <= 8'hFF;
      status_q <= ST_OK;
    end else begin
      done_q <= 1'b0;
      if (spi_start_o) pend_q <= 1'b1;
      else if (got)    pend_q <= 1'b0;

      case (state_q)
        S_IDLE: if (start_i) begin
          cmd_q   <= cmd_idx_i;
          arg_q   <= cmd_arg_i;
          app_q   <= app_cmd_i;
          is55_q  <= app_cmd_i;
          tries_q <= '0;
          tout_q  <= 1'b0;
          trail_q <= '0;
          cs_n_q  <= 1'b1;
          cnt_q   <= '0;
          state_q <= S_FILL;
        end
        S_FILL: if (got) begin
          cs_n_q  <= 1'b0;
          cnt_q   <= '0;
          state_q <= (cmd_q == IDX_STOP) ? S_SEND : S_RDY;
        end
        S_RDY: if (got) begin
          if (spi_rx_i == FILL_BYTE || cnt_q == RDY_LAST) begin
            if (spi_rx_i != FILL_BYTE) tout_q <= 1'b1;
            cnt_q   <= '0;
            state_q <= S_SEND;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_SEND: if (got) begin
          if (cnt_q == PKT_LAST) begin
            cnt_q   <= '0;
            state_q <= (!is55_q && cmd_q == IDX_STOP) ? S_STUFF : S_POLL;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_STUFF: if (got) state_q <= S_POLL;
        S_POLL: if (got) begin
          if (!spi_rx_i[7] || cnt_q == POLL_LAST) begin
            cnt_q <= '0;
            if (is55_q) begin
              is55_q  <= 1'b0;
              state_q <= S_RDY;
            end else if (poll_b == FILL_BYTE && tries_q != TRY_LAST) begin
              tries_q <= tries_q + 1'b1;
              is55_q  <= app_q;
              state_q <= S_SEND;
            end else begin
              r1_q     <= poll_b;
              status_q <= poll_cls;
              if (poll_cls inside {ST_NODEV, ST_CRC, ST_ILLEGAL}) state_q <= S_END;
              else if (has_trailer(cmd_q))                         state_q <= S_TRAIL;
              else if (has_busy(cmd_q))                            state_q <= S_BUSY;
              else                                                 state_q <= S_END;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_TRAIL: if (got) begin
          trail_q <= {trail_q[23:0], spi_rx_i};
          if (cnt_q == TRL_LAST) state_q <= S_END;
          else cnt_q <= cnt_q + 1'b1;
        end
        S_BUSY: if (got) begin
          if (spi_rx_i == FILL_BYTE) state_q <= S_END;
          else if (cnt_q == BUSY_LAST) begin
            tout_q  <= 1'b1;
            state_q <= S_END;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_END: begin
          if (status_q == ST_OK && keeps_select(cmd_q)) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            cs_n_q  <= 1'b1;
            state_q <= S_DESEL;
          end
        end
        S_DESEL: if (got) begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R3: bytes exchanged while deselected carry fill only
  a_r3_fill_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_start_o && cs_n_o |-> spi_tx_o == FILL_BYTE);
  // R11: completion is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11: card stays selected at completion only after a clean reply
  a_r11_hold_only_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !cs_n_o |-> status_o == ST_OK);
  // R8: no-device result carries the 0xFF reply
  a_r8_nodev_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && status_o == ST_NODEV |-> r1_o == 8'hFF);
  // R8: CRC result always has bit 3 set
  a_r8_crc_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && status_o == ST_CRC |-> r1_o[3]);
  // R5: a reply never carries bit 7 unless it is the no-reply value
  a_r5_reply_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && r1_o[7] |-> r1_o == 8'hFF);
  // R12: one exchange request at a time
  a_r12_single_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_start_o |=> !spi_start_o);

endmodule

// File: tb/tb_sd_cmd_engine.sv
`timescale 1ns/1ps
module tb_sd_cmd_engine;
  localparam int RDY = 8;
  localparam int BSY = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic        app = 1'b0;
  logic [7:0]  spi_tx, spi_rx;
  logic        spi_start, spi_done;
  logic        cs_n, busy, done, tmo;
  logic [7:0]  r1;
  logic [31:0] trail;
  logic [2:0]  status;

  always #4 clk = ~clk;

  sd_cmd_engine #(.RDY_LIMIT(RDY), .BUSY_LIMIT(BSY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_idx_i(cmd_idx),
    .cmd_arg_i(cmd_arg), .app_cmd_i(app), .spi_tx_o(spi_tx),
    .spi_start_o(spi_start), .spi_rx_i(spi_rx), .spi_done_i(spi_done),
    .cs_n_o(cs_n), .busy_o(busy), .done_o(done), .r1_o(r1),
    .trail_o(trail), .status_o(status), .timeout_o(tmo)
  );

  // card model: replays script[n] for exchange n, logs what was sent
  logic [7:0] script [128];
  logic [7:0] log_tx [128];
  logic       log_cs [128];
  int         n;
  logic       clr = 1'b0;
  logic [1:0] dly;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n <= 0; dly <= 0; spi_done <= 1'b0; spi_rx <= 8'hFF;
    end else begin
      spi_done <= 1'b0;
      if (clr) begin
        n <= 0; dly <= 0;
      end else if (spi_start) begin
        log_tx[n[6:0]] <= spi_tx;
        log_cs[n[6:0]] <= cs_n;
        dly <= 2'd2;
      end else if (dly != 0) begin
        dly <= dly - 1'b1;
        if (dly == 2'd1) begin
          spi_done <= 1'b1;
          spi_rx   <= script[n[6:0]];
          n        <= n + 1;
        end
      end
    end
  end

  int nchk = 0, nfail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_status(input logic [7:0] b);
    if (b == 8'hFF) return 3'd1;
    if (b[3]) return 3'd2;
    if (b[2]) return 3'd3;
    if (b[1] | b[4]) return 3'd4;
    if (b[5] | b[6]) return 3'd5;
    return 3'd0;
  endfunction

  function automatic logic [7:0] exp_chk(input logic [5:0] c);
    return (c == 6'd0) ? 8'h95 : (c == 6'd8) ? 8'h87 : 8'hFF;
  endfunction

  function automatic logic exp_hold(input logic [5:0] c, input logic [2:0] st);
    return st == 3'd0 && (c == 6'd9 || c == 6'd17 || c == 6'd18 || c == 6'd24 || c == 6'd25);
  endfunction

  task automatic set_script(input logic [7:0] v);
    for (int i = 0; i < 128; i++) script[i] = v;
  endtask

  task automatic run(input logic [5:0] c, input logic [31:0] a, input logic ap);
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    cmd_idx = c; cmd_arg = a; app = ap; start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < 5000; k++) begin
      if (done) return;
      @(negedge clk);
    end
    chk("watchdog: no completion", 32'd0, 32'd1);
  endtask

  typedef struct packed {
    logic [5:0]  cmd;
    logic [31:0] arg;
    logic [7:0]  rsp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{cmd: 6'd0,  arg: 32'h00000000, rsp: 8'h01},
    '{cmd: 6'd17, arg: 32'h12345678, rsp: 8'h00},
    '{cmd: 6'd24, arg: 32'hA5C3_0F81, rsp: 8'h04},
    '{cmd: 6'd9,  arg: 32'h00000200, rsp: 8'h08},
    '{cmd: 6'd16, arg: 32'h00000200, rsp: 8'h20},
    '{cmd: 6'd32, arg: 32'hDEADBEEF, rsp: 8'h10},
    '{cmd: 6'd17, arg: 32'h0000FFFF, rsp: 8'h0C},
    '{cmd: 6'd25, arg: 32'h80000001, rsp: 8'h40},
    '{cmd: 6'd13, arg: 32'h76543210, rsp: 8'h02}
  };

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    set_script(8'hFF);
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 cs_n after reset", 32'(cs_n), 32'd1);
    chk("R12 busy after reset", 32'(busy), 32'd0);
    chk("R12 spi_start after reset", 32'(spi_start), 32'd0);
    chk("R12 done after reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table: ready at once, reply on first poll (exchange 8)
    foreach (VECS[v]) begin
      logic [2:0] st;
      logic       hold;
      set_script(8'hFF);
      script[8] = VECS[v].rsp;
      st   = exp_status(VECS[v].rsp);
      hold = exp_hold(VECS[v].cmd, st);
      run(VECS[v].cmd, VECS[v].arg, 1'b0);
      chk("R3 opening byte with cs high", 32'(log_cs[0]), 32'd1);
      chk("R1 index byte", 32'(log_tx[2]), 32'({2'b01, VECS[v].cmd}));
      chk("R1 argument bytes", {log_tx[3], log_tx[4], log_tx[5], log_tx[6]}, VECS[v].arg);
      chk("R2 check byte", 32'(log_tx[7]), 32'(exp_chk(VECS[v].cmd)));
      chk("R8 reply byte", 32'(r1), 32'(VECS[v].rsp));
      chk("R8 status", 32'(status), 32'(st));
      chk("R11 cs at done", 32'(cs_n), 32'(!hold));
      chk("R11 exchange count", 32'(n), hold ? 32'd9 : 32'd10);
    end

    // R5 R7: no reply at all, three attempts
    set_script(8'hFF);
    run(6'd17, 32'h0, 1'b0);
    chk("R7 nodev exchange count", 32'(n), 32'd69);
    chk("R7 third attempt index byte", 32'(log_tx[46]), 32'h51);
    chk("R5 nodev reply", 32'(r1), 32'hFF);
    chk("R8 nodev status", 32'(status), 32'd1);
    chk("R11 nodev cs high", 32'(cs_n), 32'd1);

    // R7: second attempt succeeds
    set_script(8'hFF);
    script[30] = 8'h00;
    run(6'd16, 32'h200, 1'b0);
    chk("R7 retry exchange count", 32'(n), 32'd32);
    chk("R7 retry resend index", 32'(log_tx[24]), 32'h50);
    chk("R7 retry status", 32'(status), 32'd0);

    // R6: application command prefix
    set_script(8'hFF);
    script[8]  = 8'h01;
    script[16] = 8'h00;
    run(6'd41, 32'h40000000, 1'b1);
    chk("R6 prefix index byte", 32'(log_tx[2]), 32'h77);
    chk("R6 prefix argument", {log_tx[3], log_tx[4], log_tx[5], log_tx[6]}, 32'h0);
    chk("R6 main index byte", 32'(log_tx[10]), 32'h69);
    chk("R6 main argument", {log_tx[11], log_tx[12], log_tx[13], log_tx[14]}, 32'h40000000);
    chk("R6 reply", 32'(r1), 32'h00);
    chk("R6 exchange count", 32'(n), 32'd18);

    // R9: trailing value for index 8
    set_script(8'hFF);
    script[8] = 8'h01;
    script[9] = 8'h00; script[10] = 8'h00; script[11] = 8'h01; script[12] = 8'hAA;
    run(6'd8, 32'h1AA, 1'b0);
    chk("R2 index 8 check byte", 32'(log_tx[7]), 32'h87);
    chk("R9 trailing value", trail, 32'h000001AA);
    chk("R9 exchange count", 32'(n), 32'd14);

    // R3 R4 R10: index 12, no ready wait, stuff byte, busy wait
    set_script(8'hFF);
    script[7]  = 8'h3F;
    script[9]  = 8'h00;
    script[10] = 8'h00;
    script[11] = 8'h00;
    run(6'd12, 32'h0, 1'b0);
    chk("R3 index 12 skips ready wait", 32'(log_tx[1]), 32'h4C);
    chk("R4 stuff byte discarded", 32'(r1), 32'h00);
    chk("R10 busy wait exchange count", 32'(n), 32'd14);
    chk("R10 no timeout", 32'(tmo), 32'd0);

    // R3: ready wait runs out
    set_script(8'hFF);
    for (int i = 1; i <= RDY; i++) script[i] = 8'h00;
    script[15] = 8'h00;
    run(6'd16, 32'h200, 1'b0);
    chk("R3 ready timeout flag", 32'(tmo), 32'd1);
    chk("R3 packet after timeout", 32'(log_tx[9]), 32'h50);
    chk("R3 ready timeout count", 32'(n), 32'd17);

    // R5: reply on the last poll
    set_script(8'hFF);
    script[23] = 8'h00;
    run(6'd17, 32'h0, 1'b0);
    chk("R5 last poll reply", 32'(r1), 32'h00);
    chk("R5 last poll count", 32'(n), 32'd24);
    chk("R11 held cs", 32'(cs_n), 32'd0);

    // R10: busy wait runs out
    set_script(8'h00);
    script[0] = 8'hFF; script[1] = 8'hFF;
    run(6'd38, 32'h0, 1'b0);
    chk("R10 busy timeout flag", 32'(tmo), 32'd1);
    chk("R10 busy timeout count", 32'(n), 32'd18);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule